// File: doc/BRIEF.md
# GHASH Hash-Subkey Power Table Builder

This block turns a 128-bit GHASH hash subkey into the operand table that a four-way aggregated GHASH engine reads. After a start pulse it moves the key into its internal lane order and pre-scales it by one bit position, folding the carry back with the field polynomial. It then forms the second, third and fourth powers of the key with one shared carry-less multiplier. For each power it writes three operand entries, and it also writes the reduction constant. A done flag rises once the whole table is written. The hashing engine then reads entries through a synchronous read port.

Every stored power is kept in the same pre-scaled form as the key. If P(n) is the GHASH field product of n copies of the key, the value stored for power n is P(n) passed through the same one-bit scaling. The hashing engine therefore needs no further correction.

Top module: `ghk_power_table`

## Requirements
- R1: `key_i[127:64]` carries key bytes 0 to 7 with byte 0 in bits [71:64] and byte 7 in bits [127:120]. `key_i[63:0]` carries bytes 8 to 15 with byte 8 in bits [7:0]. The block reverses the bytes of each 64-bit half to form K, a 128-bit value with key byte 0 in K[127:120].
- R2: The scaled key is S = K << 1. If K[127] was 1, S is then XORed with 128'hC2000000_00000000_00000000_00000001. Slots 1, 2 and 3 hold the three entries of S.
- R3: Slot 0 holds the reduction constant 128'h00000000_00000000_C2000000_00000000.
- R4: For a stored value V, the three consecutive slots of a power hold, in order, {V[63:0], 64'h0}, then {V[63:0], V[127:64]}, then {64'h0, V[127:64]}.
- R5: Slots 4 to 6 hold the entries of the scaled form of K·K. The product is in the GHASH field x^128 + x^7 + x^2 + x + 1, with K[127] as the x^0 coefficient.
- R6: Slots 7 to 9 hold the entries of the scaled K^3, and slots 10 to 12 hold those of the scaled K^4.
- R7: `done_o` is 0 after reset. It rises only in the cycle after slot 12 is written and stays 1 until the next start. A start while `done_o` is 1 clears `done_o` on the next cycle and rebuilds the table.
- R8: A start pulse while a build is in progress is ignored. The finished table reflects the key of the accepted start.
- R9: A read returns the addressed entry one cycle after `rd_addr_i` is sampled. If the same slot is written in that cycle, the read returns the previous contents, and the new contents appear from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to build the table from `key_i` |
| key_i | input | 128 | Hash subkey, little-endian bytes within each 64-bit lane |
| done_o | output | 1 | Table complete, held until the next accepted start |
| rd_addr_i | input | 4 | Table read slot |
| rd_data_o | output | 128 | Registered table entry |

## Verification
The builder writes the table while the hashing side may be reading it, so a read and a write can land on the same slot in the same cycle. The bench provokes this with a restart on a new key while slot 1 is addressed. It lines up the read with the write of slot 1 two cycles later. The returned value must still be the old key's entry, and the new entry must appear one cycle after. The same restart also lands a start on a finished table, which must drop the done flag at once.

// File: rtl/ghk_pkg.sv
package ghk_pkg;
  localparam int LANE_W     = 64;
  localparam int BLK_W      = 2 * LANE_W;
  localparam int NUM_POWERS = 4;
  localparam int NUM_SLOTS  = 1 + 3 * NUM_POWERS;
  localparam int SLOT_AW    = $clog2(NUM_SLOTS);
  localparam int LAST_SLOT  = NUM_SLOTS - 1;

  localparam logic [LANE_W-1:0] RED_K    = 64'hC200_0000_0000_0000;
  localparam logic [BLK_W-1:0]  KEY_FOLD = {8'hC2, {(BLK_W-16){1'b0}}, 8'h01};
  localparam logic [BLK_W-1:0]  CONST_ENTRY = {{LANE_W{1'b0}}, RED_K};

  typedef logic [BLK_W-1:0] blk_t;

  typedef enum logic [2:0] {ST_IDLE, ST_WRITE, ST_ISSUE, ST_WAIT, ST_DONE} seq_st_t;
  typedef enum logic [1:0] {ENT_LO, ENT_MID, ENT_HI} ent_kind_t;

  function automatic logic [LANE_W-1:0] lane_bswap(input logic [LANE_W-1:0] v);
    logic [LANE_W-1:0] r;
    for (int i = 0; i < LANE_W / 8; i++) r[8*i +: 8] = v[LANE_W-8-8*i +: 8];
    return r;
  endfunction

  function automatic blk_t key_to_internal(input blk_t w);
    return {lane_bswap(w[BLK_W-1:LANE_W]), lane_bswap(w[LANE_W-1:0])};
  endfunction

  // One-bit pre-scaling with polynomial fold of the carried-out bit
  function automatic blk_t prescale(input blk_t v);
    blk_t r;
    r = {v[BLK_W-2:0], 1'b0};
    if (v[BLK_W-1]) r = r ^ KEY_FOLD;
    return r;
  endfunction

  function automatic blk_t entry_of(input blk_t v, input ent_kind_t k);
    case (k)
      ENT_LO:  return {v[LANE_W-1:0], {LANE_W{1'b0}}};
      ENT_MID: return {v[LANE_W-1:0], v[BLK_W-1:LANE_W]};
      default: return {{LANE_W{1'b0}}, v[BLK_W-1:LANE_W]};
    endcase
  endfunction
endpackage

// File: rtl/ghk_clmul.sv
module ghk_clmul #(
  parameter int W    = 64,
  parameter int STEP = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic           fin,
  output logic [2*W-1:0] res
);
  localparam int ITER  = W / STEP;
  localparam int CNT_W = $clog2(ITER + 1);

  logic [2*W-1:0] sa, acc;
  logic [W-1:0]   sb;
  logic [CNT_W-1:0] cnt;
  logic busy_q, fin_q;
  logic [2*W-1:0] part [STEP+1];

  assign part[0] = acc;
  for (genvar k = 0; k < STEP; k++) begin : g_bit
    assign part[k+1] = part[k] ^ (sb[k] ? (sa << k) : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      cnt    <= '0;
      sa     <= '0;
      sb     <= '0;
      acc    <= '0;
    end else begin
      fin_q <= 1'b0;
      if (go && !busy_q) begin
        sa     <= {{W{1'b0}}, a};
        sb     <= b;
        acc    <= '0;
        cnt    <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        acc <= part[STEP];
        sa  <= sa << STEP;
        sb  <= sb >> STEP;
        cnt <= cnt + 1'b1;
        if (cnt == CNT_W'(ITER - 1)) begin
          busy_q <= 1'b0;
          fin_q  <= 1'b1;
        end
      end
    end
  end

  assign fin = fin_q;
  assign res = acc;
endmodule

// File: rtl/ghk_table.sv
module ghk_table #(
  parameter int DW = 128,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ghk_seq.sv
module ghk_seq
  import ghk_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  blk_t               key,
  output logic               done,
  output logic               tbl_we,
  output logic [SLOT_AW-1:0] tbl_waddr,
  output blk_t               tbl_wdata,
  output logic               mul_go,
  output logic [LANE_W-1:0]  mul_a,
  output logic [LANE_W-1:0]  mul_b,
  input  logic               mul_fin,
  input  blk_t               mul_res
);
  localparam int ACC_W   = 2 * BLK_W;
  localparam int LAST_OP = 5;

  seq_st_t st;
  blk_t h1, h2, wval, ma, mb;
  logic [ACC_W-1:0] acc, acc_next, ext;
  logic [SLOT_AW-1:0] slot;
  ent_kind_t kind;
  logic [1:0] mul_idx;
  logic [2:0] op;
  logic done_q;

  // Operand pairs: four partial products, then two folds by the constant
  always_comb begin
    ma = (mul_idx == 2'd0) ? h1 : h2;
    mb = (mul_idx == 2'd2) ? h2 : h1;
    case (op)
      3'd0: begin mul_a = ma[LANE_W-1:0];     mul_b = mb[LANE_W-1:0];     end
      3'd1: begin mul_a = ma[LANE_W-1:0];     mul_b = mb[BLK_W-1:LANE_W]; end
      3'd2: begin mul_a = ma[BLK_W-1:LANE_W]; mul_b = mb[LANE_W-1:0];     end
      3'd3: begin mul_a = ma[BLK_W-1:LANE_W]; mul_b = mb[BLK_W-1:LANE_W]; end
      default: begin mul_a = acc[LANE_W-1:0]; mul_b = RED_K;               end
    endcase
  end

  always_comb begin
    ext = {{BLK_W{1'b0}}, mul_res};
    case (op)
      3'd0:      acc_next = acc ^ ext;
      3'd1, 3'd2: acc_next = acc ^ (ext << LANE_W);
      3'd3:      acc_next = acc ^ (ext << BLK_W);
      default:   acc_next = (acc >> LANE_W)
                            ^ {{BLK_W{1'b0}}, acc[LANE_W-1:0], {LANE_W{1'b0}}}
                            ^ ext;
    endcase
  end

  assign tbl_we    = (st == ST_WRITE);
  assign tbl_waddr = slot;
  assign tbl_wdata = (slot == '0) ? CONST_ENTRY : entry_of(wval, kind);
  assign mul_go    = (st == ST_ISSUE);
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      done_q  <= 1'b0;
      slot    <= '0;
      kind    <= ENT_LO;
      mul_idx <= '0;
      op      <= '0;
      acc     <= '0;
      h1      <= '0;
      h2      <= '0;
      wval    <= '0;
    end else begin
      case (st)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            h1      <= prescale(key_to_internal(key));
            wval    <= prescale(key_to_internal(key));
            slot    <= '0;
            kind    <= ENT_LO;
            mul_idx <= '0;
            done_q  <= 1'b0;
            st      <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          slot <= slot + 1'b1;
          if (slot != '0) begin
            case (kind)
              ENT_LO:  kind <= ENT_MID;
              ENT_MID: kind <= ENT_HI;
              default: kind <= ENT_LO;
            endcase
          end
          if (slot == SLOT_AW'(LAST_SLOT)) begin
            st     <= ST_DONE;
            done_q <= 1'b1;
          end else if (slot != '0 && kind == ENT_HI) begin
            st  <= ST_ISSUE;
            op  <= '0;
            acc <= '0;
          end
        end
        ST_ISSUE: st <= ST_WAIT;
        ST_WAIT: begin
          if (mul_fin) begin
            acc <= acc_next;
            if (op == 3'(LAST_OP)) begin
              wval <= acc_next[BLK_W-1:0];
              if (mul_idx == 2'd0) h2 <= acc_next[BLK_W-1:0];
              mul_idx <= mul_idx + 2'd1;
              st      <= ST_WRITE;
            end else begin
              op <= op + 3'd1;
              st <= ST_ISSUE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ghk_power_table.sv
module ghk_power_table
  import ghk_pkg::*;
#(
  parameter int CLMUL_STEP = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [BLK_W-1:0]   key_i,
  output logic               done_o,
  input  logic [SLOT_AW-1:0] rd_addr_i,
  output logic [BLK_W-1:0]   rd_data_o
);
  logic               tbl_we;
  logic [SLOT_AW-1:0] tbl_waddr;
  blk_t               tbl_wdata;
  logic               mul_go, mul_fin;
  logic [LANE_W-1:0]  mul_a, mul_b;
  blk_t               mul_res;

  ghk_seq i_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start_i),
    .key       (key_i),
    .done      (done_o),
    .tbl_we    (tbl_we),
    .tbl_waddr (tbl_waddr),
    .tbl_wdata (tbl_wdata),
    .mul_go    (mul_go),
    .mul_a     (mul_a),
    .mul_b     (mul_b),
    .mul_fin   (mul_fin),
    .mul_res   (mul_res)
  );

  ghk_clmul #(.W(LANE_W), .STEP(CLMUL_STEP)) i_mul (
    .clk (clk),
    .rst (rst),
    .go  (mul_go),
    .a   (mul_a),
    .b   (mul_b),
    .fin (mul_fin),
    .res (mul_res)
  );

  ghk_table #(.DW(BLK_W), .AW(SLOT_AW)) i_tbl (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_waddr),
    .wdata (tbl_wdata),
    .raddr (rd_addr_i),
    .rdata (rd_data_o)
  );
endmodule

// File: rtl/ghk_checker.sv
module ghk_checker
  import ghk_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               start_i,
  input logic               done_o,
  input logic               tbl_we,
  input logic [SLOT_AW-1:0] tbl_waddr
);
  logic [SLOT_AW-1:0] last_waddr;

  always_ff @(posedge clk) begin
    if (rst) last_waddr <= '0;
    else if (tbl_we) last_waddr <= tbl_waddr;
  end

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    done_o && !start_i |=> done_o); // R7
  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    done_o && start_i |=> !done_o); // R7
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(tbl_we) && $past(tbl_waddr) == SLOT_AW'(LAST_SLOT)); // R7
  AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !tbl_we); // R7
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
    tbl_we |-> tbl_waddr <= SLOT_AW'(LAST_SLOT)); // R4
  AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (rst)
    tbl_we && tbl_waddr != '0 |-> tbl_waddr == last_waddr + 1'b1); // R6
endmodule

bind ghk_power_table ghk_checker i_chk (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .done_o    (done_o),
  .tbl_we    (tbl_we),
  .tbl_waddr (tbl_waddr)
);

// File: tb/test_ghk_power_table.sv
`timescale 1ns/1ps
module test_ghk_power_table;
  logic         clk = 1'b0;
  logic         rst;
  logic         start_i;
  logic [127:0] key_i;
  logic         done_o;
  logic [3:0]   rd_addr_i;
  logic [127:0] rd_data_o;

  int checks = 0;
  int errors = 0;

  localparam logic [127:0] KEYS [4] = '{
    128'h66e94bd4ef8a2c3b884cfa59ca342b2e,
    128'hb83b533708bf535d0aa6e52980d53b78,
    128'h80000000000000000000000000000000,
    128'h00000000000000000000000000000001
  };

  always #2.5 clk = ~clk;

  ghk_power_table i_ghk_power_table (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .key_i     (key_i),
    .done_o    (done_o),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  // ---------------- reference model ----------------
  function automatic logic [63:0] bswap64(input logic [63:0] v);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = v[56-8*i +: 8];
    return r;
  endfunction

  function automatic logic [127:0] wire_of(input logic [127:0] k);
    return {bswap64(k[127:64]), bswap64(k[63:0])};
  endfunction

  // bit-serial GHASH field multiply, bit 127 is the x^0 coefficient
  function automatic logic [127:0] gf_mul(input logic [127:0] x, input logic [127:0] y);
    logic [127:0] z;
    logic [127:0] v;
    z = '0;
    v = y;
    for (int i = 0; i < 128; i++) begin
      if (x[127-i]) z = z ^ v;
      if (v[0]) v = (v >> 1) ^ {8'hE1, 120'h0};
      else      v = v >> 1;
    end
    return z;
  endfunction

  function automatic logic [127:0] scale_ref(input logic [127:0] v);
    logic [127:0] r;
    r = {v[126:0], 1'b0};
    if (v[127]) r = r ^ {8'hC2, 112'h0, 8'h01};
    return r;
  endfunction

  function automatic logic [127:0] slot_ref(input logic [127:0] k, input int s);
    logic [127:0] p;
    logic [127:0] v;
    int g;
    if (s == 0) return {64'h0, 64'hC200000000000000};
    g = (s - 1) / 3;
    p = k;
    for (int n = 0; n < g; n++) p = gf_mul(p, k);
    v = scale_ref(p);
    case ((s - 1) % 3)
      0:       return {v[63:0], 64'h0};
      1:       return {v[63:0], v[127:64]};
      default: return {64'h0, v[127:64]};
    endcase
  endfunction

  // ---------------- helpers ----------------
  task automatic check_val(input string req, input string what,
                           input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [127:0] k);
    @(negedge clk);
    key_i   = wire_of(k);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (!done_o && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (!done_o) begin
      checks++;
      errors++;
      $display("FAIL R7 build did not finish: actual done=0 expected done=1");
    end
  endtask

  task automatic read_slot(input int s, output logic [127:0] d);
    @(negedge clk);
    rd_addr_i = 4'(s);
    @(negedge clk);
    d = rd_data_o;
  endtask

  function automatic string slot_tag(input int s);
    if (s == 0) return "R3";
    if (s <= 3) return "R1 R2 R4";
    if (s <= 6) return "R5 R4";
    return "R6 R4";
  endfunction

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] d;
    rst = 1'b1;
    start_i = 1'b0;
    key_i = '0;
    rd_addr_i = '0;
    repeat (4) @(negedge clk);
    check_val("R7", "done after reset", {127'h0, done_o}, 128'h0);
    rst = 1'b0;

    // table walk over the key vectors
    for (int k = 0; k < 4; k++) begin
      pulse_start(KEYS[k]);
      check_val("R7", "done cleared by start", {127'h0, done_o}, 128'h0);
      wait_done();
      check_val("R7", "done after build", {127'h0, done_o}, 128'h1);
      for (int s = 0; s < 13; s++) begin
        read_slot(s, d);
        check_val(slot_tag(s), $sformatf("key %0d slot %0d", k, s), d, slot_ref(KEYS[k], s));
      end
      check_val("R7", "done held", {127'h0, done_o}, 128'h1);
    end

    // R8: a second start during a build is ignored
    pulse_start(KEYS[0]);
    repeat (30) @(negedge clk);
    pulse_start(KEYS[1]);
    check_val("R8", "done low while busy", {127'h0, done_o}, 128'h0);
    wait_done();
    read_slot(11, d);
    check_val("R8", "slot 11 keeps first key", d, slot_ref(KEYS[0], 11));
    read_slot(2, d);
    check_val("R8", "slot 2 keeps first key", d, slot_ref(KEYS[0], 2));

    // R9: restart while reading slot 1, read lands on its write cycle
    @(negedge clk);
    key_i     = wire_of(KEYS[2]);
    start_i   = 1'b1;
    rd_addr_i = 4'd1;
    @(negedge clk);
    start_i = 1'b0;
    check_val("R7", "restart drops done", {127'h0, done_o}, 128'h0);
    @(negedge clk);
    @(negedge clk);
    check_val("R9", "read during write returns old", rd_data_o, slot_ref(KEYS[0], 1));
    @(negedge clk);
    check_val("R9", "new entry next cycle", rd_data_o, slot_ref(KEYS[2], 1));
    wait_done();
    read_slot(12, d);
    check_val("R6", "unit key slot 12", d, slot_ref(KEYS[2], 12));
    read_slot(0, d);
    check_val("R3", "constant after restart", d, slot_ref(KEYS[2], 0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule